// File: doc/BRIEF.md
# Wrong-Path Distance Predictor Table

This block is a direct-mapped table used for early branch-misprediction recovery. When an instruction shows behaviour that almost only happens on a wrong path (a wrong-path event), the core reads the table. The read uses the low bits of that instruction's address and the recent global branch history. The table answers whether it has learned a distance for this case. The distance says how many instructions older than the event the mispredicted branch sits. When the branch was indirect, the table also returns the correct target to redirect to.

Training happens when the oldest mispredicted branch retires. If the core recorded an event on that branch's wrong path, it presents the oldest event's address bits, history and sequence number, together with the branch's sequence number and target. The table stores the circular difference of the two sequence numbers. The update is spread over three clock edges, and a busy flag covers that time. A separate invalidate port clears an entry whose prediction led to flushing correct-path work.

Top module: `dist_pred_table`

## Requirements
- R1: Reset clears every entry's valid bit; a read of any index after reset returns rdValid = 0.
- R2: The entry index is `pcLo XOR hist` (both IDX_W bits wide). Two (pcLo, hist) pairs with the same XOR share one entry.
- R3: Reads are registered: the outputs show the entry selected by the read inputs at the previous clock edge. A read on the same edge that writes that entry returns the old contents.
- R4: An update accepted with updEvtSeen = 1 sets the entry valid and stores the distance `(updEvtSeq - updBrSeq) mod 2^SEQ_W`.
- R5: An update presented with updEvtSeen = 0 leaves the table unchanged and does not raise updBusy.
- R6: A computed distance of 0, or one above 2^DIST_W - 1, is not written: the entry keeps its old contents.
- R7: An update with updIsInd = 1 stores updTgt and returns rdHasTgt = 1 on later reads; an update with updIsInd = 0 makes rdHasTgt = 0.
- R8: invReq clears the selected entry's valid bit at the next edge. If an update writes the same index on that edge, the clear wins.
- R9: After an accepted update, updBusy is 1 for exactly two cycles and the write lands on the second edge after acceptance. Update requests made while updBusy = 1 are ignored.
- R10: Sequence numbers wrap: an event sequence number that is numerically below the branch's still yields the modular difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdPcLo | input | IDX_W | Low address bits of the event instruction being looked up |
| rdHist | input | IDX_W | Most recent global history bits for the lookup |
| rdValid | output | 1 | Looked-up entry holds a learned distance |
| rdDist | output | DIST_W | Learned distance in instructions |
| rdHasTgt | output | 1 | Entry carries an indirect-branch target |
| rdTgt | output | TGT_W | Stored indirect-branch target |
| updReq | input | 1 | Oldest mispredicted branch is retiring |
| updEvtSeen | input | 1 | An event was recorded on that branch's wrong path |
| updPcLo | input | IDX_W | Low address bits of the oldest recorded event |
| updHist | input | IDX_W | History bits recorded with that event |
| updEvtSeq | input | SEQ_W | Circular sequence number of that event |
| updBrSeq | input | SEQ_W | Circular sequence number of the branch |
| updIsInd | input | 1 | The branch is indirect |
| updTgt | input | TGT_W | Correct target of the branch |
| updBusy | output | 1 | An update is in progress |
| invReq | input | 1 | Clear the selected entry |
| invPcLo | input | IDX_W | Address bits for the entry to clear |
| invHist | input | IDX_W | History bits for the entry to clear |

## Verification
The bench builds the table with IDX_W = 4, DIST_W = 8, SEQ_W = 9 and TGT_W = 16. With 16 entries, aliasing between different address/history pairs is easy to set up and every entry can be swept after reset. With 9-bit sequence numbers against 8-bit distances, both out-of-range cases are reachable: a difference of exactly 256, and a zero difference. Wraparound across the top of the sequence space is also reachable. The short update pipeline lets the bench line up a read, and an invalidate, with the write edge itself.

// File: rtl/dpt_pkg.sv
package dpt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CALC  = 2'd1,
    ST_WRITE = 2'd2
  } updState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;  // capture update operands
    logic calc;   // register distance and range check
    logic write;  // commit to storage
  } ctlStrobes_t;

endpackage

// File: rtl/dpt_ctrl.sv
module dpt_ctrl
  import dpt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        updReq,
  input  logic        updEvtSeen,
  output ctlStrobes_t strobe,
  output logic        busy
);

  updState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (updReq && updEvtSeen) begin
          strobe.latch = 1'b1;
          stateD       = ST_CALC;
        end
      end
      ST_CALC: begin
        strobe.calc = 1'b1;
        stateD      = ST_WRITE;
      end
      ST_WRITE: begin
        strobe.write = 1'b1;
        stateD       = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy = (stateQ != ST_IDLE);

endmodule

// File: rtl/dpt_datapath.sv
module dpt_datapath
  import dpt_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DIST_W = 8,
  parameter int SEQ_W  = 9,
  parameter int TGT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobe,
  input  logic [IDX_W-1:0]  rdPcLo,
  input  logic [IDX_W-1:0]  rdHist,
  output logic              rdValid,
  output logic [DIST_W-1:0] rdDist,
  output logic              rdHasTgt,
  output logic [TGT_W-1:0]  rdTgt,
  input  logic [IDX_W-1:0]  updPcLo,
  input  logic [IDX_W-1:0]  updHist,
  input  logic [SEQ_W-1:0]  updEvtSeq,
  input  logic [SEQ_W-1:0]  updBrSeq,
  input  logic              updIsInd,
  input  logic [TGT_W-1:0]  updTgt,
  input  logic              invReq,
  input  logic [IDX_W-1:0]  invPcLo,
  input  logic [IDX_W-1:0]  invHist
);

  localparam int ENTRIES  = 1 << IDX_W;
  localparam int MAX_DIST = (1 << DIST_W) - 1;

  // index hashing
  logic [IDX_W-1:0] rdIdx, invIdx;
  assign rdIdx  = rdPcLo ^ rdHist;
  assign invIdx = invPcLo ^ invHist;

  // stage 1: operand capture
  logic [IDX_W-1:0] wIdxQ;
  logic [SEQ_W-1:0] evtSeqQ, brSeqQ;
  logic             isIndQ;
  logic [TGT_W-1:0] tgtLatQ;

  always_ff @(posedge clk) begin
    if (strobe.latch) begin
      wIdxQ   <= updPcLo ^ updHist;
      evtSeqQ <= updEvtSeq;
      brSeqQ  <= updBrSeq;
      isIndQ  <= updIsInd;
      tgtLatQ <= updTgt;
    end
  end

  // stage 2: circular distance and range check
  logic [SEQ_W-1:0]  seqDiff;
  logic              inRange;
  logic [DIST_W-1:0] distQ;
  logic              okQ;

  assign seqDiff = evtSeqQ - brSeqQ;
  assign inRange = (seqDiff != '0) && (seqDiff <= SEQ_W'(MAX_DIST));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      okQ <= 1'b0;
    end else if (strobe.calc) begin
      okQ <= inRange;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.calc) distQ <= seqDiff[DIST_W-1:0];
  end

  // stage 3: storage
  logic [ENTRIES-1:0] validQ;
  logic [DIST_W-1:0]  distMem [ENTRIES];
  logic               indMem  [ENTRIES];
  logic [TGT_W-1:0]   tgtMem  [ENTRIES];
  logic               doWrite;

  assign doWrite = strobe.write && okQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else begin
      if (doWrite) validQ[wIdxQ] <= 1'b1;
      if (invReq)  validQ[invIdx] <= 1'b0;  // clear beats a same-index write
    end
  end

  always_ff @(posedge clk) begin
    if (doWrite) begin
      distMem[wIdxQ] <= distQ;
      indMem[wIdxQ]  <= isIndQ;
      tgtMem[wIdxQ]  <= tgtLatQ;
    end
  end

  // registered read port, sees contents before this edge's write
  logic              rdValidQ, rdHasTgtQ;
  logic [DIST_W-1:0] rdDistQ;
  logic [TGT_W-1:0]  rdTgtQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValidQ  <= 1'b0;
      rdHasTgtQ <= 1'b0;
    end else begin
      rdValidQ  <= validQ[rdIdx];
      rdHasTgtQ <= indMem[rdIdx];
    end
  end

  always_ff @(posedge clk) begin
    rdDistQ <= distMem[rdIdx];
    rdTgtQ  <= tgtMem[rdIdx];
  end

  assign rdValid  = rdValidQ;
  assign rdDist   = rdDistQ;
  assign rdHasTgt = rdHasTgtQ;
  assign rdTgt    = rdTgtQ;

endmodule

// File: rtl/dist_pred_table.sv
module dist_pred_table
  import dpt_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DIST_W = 8,
  parameter int SEQ_W  = 9,
  parameter int TGT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  rdPcLo,
  input  logic [IDX_W-1:0]  rdHist,
  output logic              rdValid,
  output logic [DIST_W-1:0] rdDist,
  output logic              rdHasTgt,
  output logic [TGT_W-1:0]  rdTgt,
  input  logic              updReq,
  input  logic              updEvtSeen,
  input  logic [IDX_W-1:0]  updPcLo,
  input  logic [IDX_W-1:0]  updHist,
  input  logic [SEQ_W-1:0]  updEvtSeq,
  input  logic [SEQ_W-1:0]  updBrSeq,
  input  logic              updIsInd,
  input  logic [TGT_W-1:0]  updTgt,
  output logic              updBusy,
  input  logic              invReq,
  input  logic [IDX_W-1:0]  invPcLo,
  input  logic [IDX_W-1:0]  invHist
);

  ctlStrobes_t strobe;

  dpt_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .updReq     (updReq),
    .updEvtSeen (updEvtSeen),
    .strobe     (strobe),
    .busy       (updBusy)
  );

  dpt_datapath #(
    .IDX_W  (IDX_W),
    .DIST_W (DIST_W),
    .SEQ_W  (SEQ_W),
    .TGT_W  (TGT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rdPcLo    (rdPcLo),
    .rdHist    (rdHist),
    .rdValid   (rdValid),
    .rdDist    (rdDist),
    .rdHasTgt  (rdHasTgt),
    .rdTgt     (rdTgt),
    .updPcLo   (updPcLo),
    .updHist   (updHist),
    .updEvtSeq (updEvtSeq),
    .updBrSeq  (updBrSeq),
    .updIsInd  (updIsInd),
    .updTgt    (updTgt),
    .invReq    (invReq),
    .invPcLo   (invPcLo),
    .invHist   (invHist)
  );

endmodule

// File: rtl/dpt_checker.sv
module dpt_checker #(
  parameter int IDX_W  = 8,
  parameter int DIST_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              updReq,
  input logic              updEvtSeen,
  input logic              updBusy,
  input logic              rdValid,
  input logic [DIST_W-1:0] rdDist,
  input logic [IDX_W-1:0]  rdPcLo,
  input logic [IDX_W-1:0]  rdHist,
  input logic              invReq,
  input logic [IDX_W-1:0]  invPcLo,
  input logic [IDX_W-1:0]  invHist
);

  logic             invQ;
  logic [IDX_W-1:0] invIdxQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      invQ    <= 1'b0;
      invIdxQ <= '0;
    end else begin
      invQ    <= invReq;
      invIdxQ <= invPcLo ^ invHist;
    end
  end

  // R9: an accepted update raises busy
  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (updReq && updEvtSeen && !updBusy) |=> updBusy);

  // R9: busy never lasts beyond two cycles
  p_busy_bounded_r9: assert property (@(posedge clk) disable iff (!rstN)
    (updBusy && $past(updBusy)) |=> !updBusy);

  // R5: a retire without a recorded event starts nothing
  p_no_event_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (updReq && !updEvtSeen && !updBusy) |=> !updBusy);

  // R6: a valid entry never reports a zero distance
  p_dist_nonzero_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdDist != '0));

  // R8: after a clear, a read of that index sees it invalid
  p_inv_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (invQ && ((rdPcLo ^ rdHist) == invIdxQ) && !updBusy) |=> !rdValid);

endmodule

bind dist_pred_table dpt_checker #(
  .IDX_W  (IDX_W),
  .DIST_W (DIST_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .updReq     (updReq),
  .updEvtSeen (updEvtSeen),
  .updBusy    (updBusy),
  .rdValid    (rdValid),
  .rdDist     (rdDist),
  .rdPcLo     (rdPcLo),
  .rdHist     (rdHist),
  .invReq     (invReq),
  .invPcLo    (invPcLo),
  .invHist    (invHist)
);

// File: tb/sim_dist_pred_table.sv
module sim_dist_pred_table;

  localparam int IDX_W  = 4;
  localparam int DIST_W = 8;
  localparam int SEQ_W  = 9;
  localparam int TGT_W  = 16;
  localparam int NVEC   = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [IDX_W-1:0]  rdPcLo = '0, rdHist = '0;
  logic              rdValid, rdHasTgt;
  logic [DIST_W-1:0] rdDist;
  logic [TGT_W-1:0]  rdTgt;
  logic              updReq = 1'b0, updEvtSeen = 1'b0, updIsInd = 1'b0;
  logic [IDX_W-1:0]  updPcLo = '0, updHist = '0;
  logic [SEQ_W-1:0]  updEvtSeq = '0, updBrSeq = '0;
  logic [TGT_W-1:0]  updTgt = '0;
  logic              updBusy;
  logic              invReq = 1'b0;
  logic [IDX_W-1:0]  invPcLo = '0, invHist = '0;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dist_pred_table #(
    .IDX_W(IDX_W), .DIST_W(DIST_W), .SEQ_W(SEQ_W), .TGT_W(TGT_W)
  ) u0 (
    .clk(clk), .rstN(rstN),
    .rdPcLo(rdPcLo), .rdHist(rdHist),
    .rdValid(rdValid), .rdDist(rdDist), .rdHasTgt(rdHasTgt), .rdTgt(rdTgt),
    .updReq(updReq), .updEvtSeen(updEvtSeen),
    .updPcLo(updPcLo), .updHist(updHist),
    .updEvtSeq(updEvtSeq), .updBrSeq(updBrSeq),
    .updIsInd(updIsInd), .updTgt(updTgt), .updBusy(updBusy),
    .invReq(invReq), .invPcLo(invPcLo), .invHist(invHist)
  );

  typedef struct packed {
    logic [IDX_W-1:0]  pc;
    logic [IDX_W-1:0]  hist;
    logic              evt;
    logic [SEQ_W-1:0]  eSeq;
    logic [SEQ_W-1:0]  bSeq;
    logic              ind;
    logic [TGT_W-1:0]  tgt;
    logic              expV;
    logic [DIST_W-1:0] expD;
    logic              expT;
    logic [TGT_W-1:0]  expTgt;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{4'h3, 4'h5, 1'b1, 9'h010, 9'h005, 1'b0, 16'h0000, 1'b1, 8'd11,  1'b0, 16'h0000}, // R4 idx 6
    '{4'h1, 4'h0, 1'b1, 9'h003, 9'h1F0, 1'b1, 16'hBEEF, 1'b1, 8'd19,  1'b1, 16'hBEEF}, // R10 wrap, R7 target
    '{4'h0, 4'hF, 1'b1, 9'h1FF, 9'h100, 1'b0, 16'h0000, 1'b1, 8'd255, 1'b0, 16'h0000}, // R4 largest distance
    '{4'h4, 4'h3, 1'b1, 9'h100, 9'h000, 1'b0, 16'h0000, 1'b0, 8'd0,   1'b0, 16'h0000}, // R6 distance 256
    '{4'h8, 4'h8, 1'b1, 9'h050, 9'h050, 1'b0, 16'h0000, 1'b0, 8'd0,   1'b0, 16'h0000}, // R6 distance 0
    '{4'h2, 4'h4, 1'b1, 9'h020, 9'h01E, 1'b0, 16'h0000, 1'b1, 8'd2,   1'b0, 16'h0000}, // R4 overwrite idx 6
    '{4'h1, 4'h0, 1'b0, 9'h030, 9'h001, 1'b1, 16'h1234, 1'b1, 8'd19,  1'b1, 16'hBEEF}, // R5 no event
    '{4'h1, 4'h0, 1'b1, 9'h008, 9'h004, 1'b0, 16'h0000, 1'b1, 8'd4,   1'b0, 16'h0000}  // R7 direct clears
  };

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic doRead(input logic [IDX_W-1:0] pc, input logic [IDX_W-1:0] h);
    @(negedge clk);
    rdPcLo = pc; rdHist = h;
    @(posedge clk);
    @(negedge clk);
  endtask

  // presents an update for one cycle, then waits out the write
  task automatic doUpdate(input logic [IDX_W-1:0] pc, input logic [IDX_W-1:0] h,
                          input logic evt, input logic [SEQ_W-1:0] es,
                          input logic [SEQ_W-1:0] bs, input logic ind,
                          input logic [TGT_W-1:0] tg);
    @(negedge clk);
    updReq = 1'b1; updEvtSeen = evt; updPcLo = pc; updHist = h;
    updEvtSeq = es; updBrSeq = bs; updIsInd = ind; updTgt = tg;
    @(posedge clk);
    @(negedge clk);
    updReq = 1'b0; updEvtSeen = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    string tag;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: every entry invalid after reset
    for (int i = 0; i < (1 << IDX_W); i++) begin
      doRead(IDX_W'(i), '0);
      chk("R1", "valid after reset", rdValid, 0);
    end
    chk("R9", "busy after reset", updBusy, 0);

    // table-driven updates and read-backs
    for (int i = 0; i < NVEC; i++) begin
      case (i)
        1: tag = "R10";
        3, 4: tag = "R6";
        6: tag = "R5";
        7: tag = "R7";
        default: tag = "R4";
      endcase
      doUpdate(VECS[i].pc, VECS[i].hist, VECS[i].evt, VECS[i].eSeq,
               VECS[i].bSeq, VECS[i].ind, VECS[i].tgt);
      doRead(VECS[i].pc, VECS[i].hist);
      chk(tag, "valid", rdValid, VECS[i].expV);
      if (VECS[i].expV) begin
        chk(tag, "distance", rdDist, VECS[i].expD);
        chk(tag, "has target", rdHasTgt, VECS[i].expT);
        if (VECS[i].expT) chk(tag, "target", rdTgt, VECS[i].expTgt);
      end
    end

    // R2: aliased pairs reach the entry last written by index 6
    doRead(4'h6, 4'h0);
    chk("R2", "alias valid", rdValid, 1);
    chk("R2", "alias distance", rdDist, 2);
    doRead(4'h3, 4'h5);
    chk("R2", "alias distance old pair", rdDist, 2);

    // R3: read of index 3 held across its write edge
    @(negedge clk);
    rdPcLo = 4'h3; rdHist = 4'h0;
    updReq = 1'b1; updEvtSeen = 1'b1; updPcLo = 4'h3; updHist = 4'h0;
    updEvtSeq = 9'h007; updBrSeq = 9'h004; updIsInd = 1'b0;
    @(posedge clk);                 // accept
    @(negedge clk);
    updReq = 1'b0; updEvtSeen = 1'b0;
    chk("R9", "busy after accept", updBusy, 1);
    @(posedge clk);                 // distance registered
    @(negedge clk);
    chk("R9", "busy second cycle", updBusy, 1);
    @(posedge clk);                 // write edge
    @(negedge clk);
    chk("R3", "read at write edge sees old", rdValid, 0);
    chk("R9", "busy drops", updBusy, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R3", "read after write valid", rdValid, 1);
    chk("R3", "read after write distance", rdDist, 3);

    // R9: a request during busy is dropped
    @(negedge clk);
    updReq = 1'b1; updEvtSeen = 1'b1; updPcLo = 4'hA; updHist = 4'h0;
    updEvtSeq = 9'h009; updBrSeq = 9'h004; updIsInd = 1'b0;
    @(posedge clk);
    @(negedge clk);
    updPcLo = 4'hB; updEvtSeq = 9'h00C;   // still requesting while busy
    @(posedge clk);
    @(negedge clk);
    updReq = 1'b0; updEvtSeen = 1'b0;
    repeat (2) @(posedge clk);
    doRead(4'hB, 4'h0);
    chk("R9", "request while busy ignored", rdValid, 0);
    doRead(4'hA, 4'h0);
    chk("R9", "accepted update valid", rdValid, 1);
    chk("R9", "accepted update distance", rdDist, 5);

    // R8: plain invalidate of index 6
    @(negedge clk);
    invReq = 1'b1; invPcLo = 4'h6; invHist = 4'h0;
    @(posedge clk);
    @(negedge clk);
    invReq = 1'b0;
    doRead(4'h6, 4'h0);
    chk("R8", "invalidated entry", rdValid, 0);
    doRead(4'hA, 4'h0);
    chk("R8", "other entry untouched", rdValid, 1);

    // R8: invalidate on the same edge as a write to index 9
    @(negedge clk);
    updReq = 1'b1; updEvtSeen = 1'b1; updPcLo = 4'h9; updHist = 4'h0;
    updEvtSeq = 9'h010; updBrSeq = 9'h001; updIsInd = 1'b0;
    @(posedge clk);                 // accept
    @(negedge clk);
    updReq = 1'b0; updEvtSeen = 1'b0;
    @(posedge clk);
    @(negedge clk);
    invReq = 1'b1; invPcLo = 4'h9; invHist = 4'h0;
    @(posedge clk);                 // write edge with clear
    @(negedge clk);
    invReq = 1'b0;
    doRead(4'h9, 4'h0);
    chk("R8", "clear beats same-edge write", rdValid, 0);

    // R1: a second reset wipes learned entries
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    doRead(4'h1, 4'h0);
    chk("R1", "entry 1 after re-reset", rdValid, 0);
    doRead(4'h0, 4'hF);
    chk("R1", "entry 15 after re-reset", rdValid, 0);

    finish();
  end

endmodule